// File: doc/BRIEF.md
# Sixteen-Lane Parallel Ramp Generator

This block produces a linear sawtooth for a converter that runs sixteen times faster than the fabric clock. On every fabric clock it presents sixteen 14-bit samples side by side. Together they form sixteen consecutive points of the ramp, ordered by serializer lane. A downstream serializer then sends lane 0 first and lane 15 last, so the analog output climbs by one code per converter sample and wraps from full scale back to zero.

The sixteen lanes share one narrow counter, which supplies the upper sample bits. Each lane's lower bits are its own fixed lane number. A ramp step costs one 10-bit increment per fabric clock, with no adder per lane. An enable input freezes the ramp. A synchronous reset restarts it at zero and marks the first output after reset as not yet valid.

Top module: `par_ramp_gen`

## Requirements
- R1: Every cycle the bus carries LANES (16) samples of SAMPLE_W (14) bits. Lane k sits in bits [14k+13:14k], so lane 0 is in bits [13:0] and lane 15 is in bits [223:210].
- R2: With c the internal 10-bit count, lane k equals 16*c + k. The lanes therefore hold 16 consecutive ramp values, ascending with the lane number.
- R3: At each clock edge where rst is low and en is high, c increases by one, so every lane rises by 16 (0x10).
- R4: The ramp wraps modulo 2^14. When lane 15 shows 0x3FFF, the next enabled edge makes lane 0 show 0x0000.
- R5: At each clock edge where rst is low and en is low, c holds and the whole sample bus stays unchanged.
- R6: An edge where rst is high sets c to zero, so lane k reads k, and drives valid_o low. Reset is synchronous and active high.
- R7: valid_o goes high at the first edge where rst is low and stays high until the next reset, whatever the level of en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the ramp on this edge when high |
| samples_o | output | 224 | Sixteen 14-bit samples, lane 0 in the lowest bits |
| valid_o | output | 1 | High once the generator has left reset |

## Verification
The assertions check on every cycle that:
- each enabled edge adds 16 to lane 0;
- a disabled edge leaves the bus unchanged;
- lane 15 stays exactly 15 above lane 0;
- the wrap from 0x3FFF goes to zero;
- reset and valid behave as required.

Only the bench scenarios can show that every lane of the full bus matches the value expected after long random enable patterns. The same holds for the full 1024-step climb up to the wrap point and for a reset in the middle of a run that restarts the sequence at zero.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
   // Number of index bits needed to number a given count of lanes.
   function automatic int lane_idx_bits(input int lanes);
      int b;
      b = 0;
      while ((1 << b) < lanes) b++;
      return b;
   endfunction

   // True when the value is a nonzero power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ramp_cnt.sv
// Shared high-order ramp counter: holds when disabled, wraps naturally.
module ramp_cnt #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ramp_lane.sv
// One output lane: shared count in the upper bits, fixed lane number below.
module ramp_lane #(
   parameter int SAMPLE_W = 14,
   parameter int IDX_W    = 4,
   parameter int IDX      = 0
) (
   input  logic [SAMPLE_W-IDX_W-1:0] hi_i,
   output logic [SAMPLE_W-1:0]       sample_o
);
   localparam logic [IDX_W-1:0] LANE_TAG = IDX_W'(IDX);

   assign sample_o = {hi_i, LANE_TAG};
endmodule

// File: rtl/par_ramp_gen.sv
module par_ramp_gen #(
   parameter int LANES    = 16,
   parameter int SAMPLE_W = 14
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   output logic [LANES*SAMPLE_W-1:0] samples_o,
   output logic                      valid_o
);
   localparam int IDX_W = ramp_pkg::lane_idx_bits(LANES);
   localparam int CNT_W = SAMPLE_W - IDX_W;

   // Elaboration-time parameter checks
   if (!ramp_pkg::is_pow2(LANES)) begin : g_bad_lanes
      $error("par_ramp_gen: LANES must be a power of two");
   end
   if (LANES < 2) begin : g_few_lanes
      $error("par_ramp_gen: LANES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_width
      $error("par_ramp_gen: SAMPLE_W must exceed the lane index width");
   end

   logic [CNT_W-1:0] hi_cnt;
   logic             valid_q;

   ramp_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .cnt_o (hi_cnt)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      ramp_lane #(
         .SAMPLE_W (SAMPLE_W),
         .IDX_W    (IDX_W),
         .IDX      (k)
      ) u_lane (
         .hi_i     (hi_cnt),
         .sample_o (samples_o[k*SAMPLE_W +: SAMPLE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b1;
      end
   end

   assign valid_o = valid_q;
endmodule

// File: rtl/par_ramp_gen_chk.sv
module par_ramp_gen_chk #(
   parameter int LANES    = 16,
   parameter int SAMPLE_W = 14
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      en,
   input logic [LANES*SAMPLE_W-1:0] samples_o,
   input logic                      valid_o
);
   localparam int                 IDX_W   = ramp_pkg::lane_idx_bits(LANES);
   localparam logic [SAMPLE_W-1:0] STEP    = SAMPLE_W'(LANES);
   localparam logic [SAMPLE_W-1:0] TOPOFF  = SAMPLE_W'(LANES - 1);
   localparam logic [SAMPLE_W-1:0] FULL    = {SAMPLE_W{1'b1}};
   localparam int                 TOP_LSB = (LANES - 1) * SAMPLE_W;

   logic [SAMPLE_W-1:0] first_s;
   logic [SAMPLE_W-1:0] last_s;
   assign first_s = samples_o[SAMPLE_W-1:0];
   assign last_s  = samples_o[TOP_LSB +: SAMPLE_W];

   // R3: an enabled edge adds one lane-count step to lane 0
   a_r3_step: assert property (@(posedge clk) disable iff (rst)
      en |=> first_s == $past(first_s) + STEP);

   // R5: a disabled edge leaves the whole bus untouched
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(samples_o));

   // R2: the top lane stays LANES-1 codes above lane 0
   a_r2_span: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> last_s == first_s + TOPOFF);

   // R4: the lane after full scale wraps to zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      (en && last_s == FULL) |=> first_s == '0);

   // R6: reset restarts at zero and drops valid
   a_r6_reset: assert property (@(posedge clk)
      rst |=> (first_s == '0 && !valid_o));

   // R7: valid rises once reset is released
   a_r7_valid: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> valid_o);

   logic unused_ok;
   assign unused_ok = ^IDX_W;
endmodule

bind par_ramp_gen par_ramp_gen_chk #(.LANES(LANES), .SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_par_ramp_gen.sv
`timescale 1ns/1ps
module sim_par_ramp_gen;
   localparam int LANES = 16;
   localparam int SW    = 14;
   localparam int MODV  = 1 << SW;
   localparam int HIMOD = MODV / LANES;

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic                  en  = 1'b0;
   logic [LANES*SW-1:0]   samples_o;
   logic                  valid_o;

   int errors = 0;
   int checks = 0;
   int exp_hi = 0;
   bit exp_valid = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   par_ramp_gen #(.LANES(LANES), .SAMPLE_W(SW)) u0 (
      .clk(clk), .rst(rst), .en(en), .samples_o(samples_o), .valid_o(valid_o)
   );

   function automatic logic [SW-1:0] exp_lane(input int hi, input int k);
      return SW'((hi * LANES + k) % MODV);
   endfunction

   // R1 R2: compare every lane at its bit position
   task automatic check_bus(input string tag);
      logic [LANES*SW-1:0] expv;
      for (int k = 0; k < LANES; k++) expv[k*SW +: SW] = exp_lane(exp_hi, k);
      checks++;
      if (samples_o !== expv) begin
         errors++;
         $display("FAIL %s bus: actual=%h expected=%h", tag, samples_o, expv);
      end
      checks++;
      if (valid_o !== exp_valid) begin
         errors++;
         $display("FAIL %s valid: actual=%b expected=%b", tag, valid_o, exp_valid);
      end
   endtask

   task automatic cyc(input bit r, input bit e, input string tag);
      @(negedge clk);
      rst = r;
      en  = e;
      @(posedge clk);
      #1;
      if (r) begin
         exp_hi = 0;
         exp_valid = 1'b0;
      end else begin
         if (e) exp_hi = (exp_hi + 1) % HIMOD;
         exp_valid = 1'b1;
      end
      check_bus(tag);
   endtask

   task automatic check_word(input string tag, input int lane,
                             input logic [SW-1:0] want);
      checks++;
      if (samples_o[lane*SW +: SW] !== want) begin
         errors++;
         $display("FAIL %s lane%0d: actual=%h expected=%h", tag, lane,
                  samples_o[lane*SW +: SW], want);
      end
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'd20240611);
      cyc(1'b1, 1'b0, "R6 reset");
      cyc(1'b1, 1'b1, "R6 reset with en");
      check_word("R6 lane index", 15, 14'd15);
      cyc(1'b0, 1'b0, "R7 valid rises with en low");
      cyc(1'b0, 1'b0, "R5 hold");
      cyc(1'b0, 1'b1, "R3 step");
      check_word("R3 lane0 plus 16", 0, 14'h10);
      // Random enable pattern
      for (int i = 0; i < 400; i++) begin
         cyc(1'b0, ($urandom_range(0, 3) != 0), "R2 R3 R5 random");
      end
      // Mid-run reset
      cyc(1'b1, 1'b1, "R6 mid-run reset");
      cyc(1'b0, 1'b1, "R7 after mid-run reset");
      // Climb to full scale
      while (exp_hi != HIMOD - 1) cyc(1'b0, 1'b1, "R3 climb");
      check_word("R4 top lane full scale", 15, 14'h3FFF);
      cyc(1'b0, 1'b0, "R5 hold at full scale");
      check_word("R4 held full scale", 15, 14'h3FFF);
      cyc(1'b0, 1'b1, "R4 wrap");
      check_word("R4 lane0 wrapped", 0, 14'h0000);
      check_word("R4 lane15 after wrap", 15, 14'h000F);
      for (int i = 0; i < 200; i++) begin
         cyc($urandom_range(0, 63) == 0, $urandom_range(0, 1) == 1, "R1 R6 random");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule